// File: doc/BRIEF.md
# Set-Associative Translation Buffer with Register Maintenance Port

This block holds a small set-associative table of virtual-to-physical page translations (4 KB pages) and resolves combinational lookups against it. A lookup presents a virtual address and the current process ID. It returns a hit flag, the physical frame number and the permission flags of the matching entry. Selecting the line, walking the page tables, raising misses and choosing a victim are left to the surrounding logic.

Software maintains the table only through three registers, selected by a 2-bit code:
- An address register holds the virtual page number (VPN).
- A miscellaneous register holds the process ID, the way select, a write-enable bit and a read strobe.
- An access register holds the frame number and the flags.

Writing the miscellaneous register with the read strobe set copies one stored entry back into the three registers. Writing the access register while write-enable is set commits the three registers as one entry. The entry goes to the line given by the low VPN bits and the way given by the way field. The geometry is set by parameters: ways a power of two from 1 to 16, lines a power of two of at least 2, and a PID width of 8 to 14 bits.

Top module: `assoc_tlb`

## Requirements
- R1: After a synchronous active-low reset, all three registers read zero and every stored entry is all-zero, so every lookup misses.
- R2: A write with select 0 stores data bits 21:2 as the VPN. The address register reads the VPN at bits 21:2 and zero in all other bits. The line index is the low log2(LINES) bits of the VPN.
- R3: A write with select 1 updates the miscellaneous register, which has this layout. Bit 0 is the read strobe and always reads 0. Bit 1 is write-enable. Bits 7:4 are the way select. Bits starting at 8 hold the PID (PID_W bits). All other bits read 0.
- R4: A select-1 write with bit 0 set reads the entry at the current line and at the way named in that same write. After the same clock edge, the entry's VPN, PID and access word appear in the registers. The way and write-enable fields take the written values.
- R5: A select-2 write always updates the access register. Only when write-enable is set does it also commit the entry {address VPN, misc PID, written access word} at (line, way). With write-enable clear, the stored entry is unchanged.
- R6: The access register holds flags in bits 4:0 (bit 0 read, bit 1 write, bit 2 execute, bit 3 global, bit 4 cached) and the frame number in bits 24:5. Its other bits read 0.
- R7: A way hits when three conditions hold: its VPN equals address bits 31:12, at least one of the read, write or execute flags is set, and either the global flag is set or its PID equals the lookup PID.
- R8: When several ways hit, the outputs carry the frame and flags of the lowest-numbered one. On a miss, the hit, frame and flags outputs are all zero.
- R9: A way select of WAYS or more changes no entry on a commit. A read-back of such a way loads all zeros.
- R10: Every (line, way) pair is written and read back independently of all the others.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 address, 1 miscellaneous, 2 access |
| reg_wdata | input | 32 | Register write data |
| addr_q | output | 32 | Address register contents |
| misc_q | output | 32 | Miscellaneous register contents |
| acc_q | output | 32 | Access register contents |
| lk_vaddr | input | 32 | Lookup virtual address |
| lk_pid | input | PID_W | Lookup process ID |
| lk_hit | output | 1 | Lookup hit |
| lk_frame | output | 20 | Frame number of the hitting entry |
| lk_flags | output | 5 | Flags of the hitting entry |

## Verification
A corrupt stored entry shows at the ports in two ways. It appears in the access, address or PID fields one cycle after a read-back of that line and way. It also appears at once on the lookup outputs, as a wrong hit, a wrong frame or a missing hit. A bad line or way decode shows up when the whole table is filled with distinct values and read back. In that case one entry's content appears at another coordinate. Priority and permission faults show up only when several ways share a VPN, or when an entry carries no access permission. Those cases are therefore set up on purpose.

// File: rtl/assoc_tlb_pkg.sv
// Shared constants and the entry type for the translation buffer.
// Assumes a 32-bit register port and a 20-bit VPN / frame (4 KB pages).
package assoc_tlb_pkg;
    localparam int VPN_W      = 20;
    localparam int FRAME_W    = 20;
    localparam int FLAG_W     = 5;
    localparam int PID_MAX_W  = 14;
    localparam int WAYF_W     = 4;
    localparam int PAGE_SHIFT = 12;

    localparam logic [1:0] SEL_ADDR = 2'd0;
    localparam logic [1:0] SEL_MISC = 2'd1;
    localparam logic [1:0] SEL_ACC  = 2'd2;

    localparam int MISC_RD_BIT   = 0;
    localparam int MISC_WE_BIT   = 1;
    localparam int MISC_WAY_LSB  = 4;
    localparam int MISC_PID_LSB  = 8;
    localparam int ADDR_VPN_LSB  = 2;
    localparam int ACC_FRAME_LSB = 5;

    localparam int FLG_RD = 0;
    localparam int FLG_WR = 1;
    localparam int FLG_EX = 2;
    localparam int FLG_GL = 3;
    localparam int FLG_CA = 4;

    typedef struct packed {
        logic [VPN_W-1:0]     vpn;
        logic [PID_MAX_W-1:0] pid;
        logic [FRAME_W-1:0]   frame;
        logic [FLAG_W-1:0]    flags;
    } tlb_ent_t;
endpackage

// File: rtl/assoc_tlb_store.sv
// Entry storage: WAYS x LINES entries, one write port, one indexed read
// port and a whole-set read for lookups. Assumes WAYS <= 16.
// A way number at or above WAYS is ignored on write and reads as zero.
module assoc_tlb_store
    import assoc_tlb_pkg::*;
#(
    parameter int WAYS   = 4,
    parameter int LINES  = 16,
    parameter int LINE_W = $clog2(LINES)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [LINE_W-1:0]      wr_line,
    input  logic [WAYF_W-1:0]      wr_way,
    input  tlb_ent_t               wr_ent,
    input  logic [LINE_W-1:0]      rd_line,
    input  logic [WAYF_W-1:0]      rd_way,
    output tlb_ent_t               rd_ent,
    input  logic [LINE_W-1:0]      lk_line,
    output tlb_ent_t [WAYS-1:0]    lk_set
);
    localparam int WAY_IDX_W = (WAYS > 1) ? $clog2(WAYS) : 1;

    tlb_ent_t mem [WAYS][LINES];

    logic                 wr_ok, rd_ok;
    logic [WAY_IDX_W-1:0] wr_idx, rd_idx;

    // Decode whether each way select names an existing way.
    always_comb begin
        wr_ok  = (int'(wr_way) < WAYS);
        rd_ok  = (int'(rd_way) < WAYS);
        wr_idx = wr_way[WAY_IDX_W-1:0];
        rd_idx = rd_way[WAY_IDX_W-1:0];
    end

    // Clear all entries on reset; otherwise commit one entry per write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int w = 0; w < WAYS; w++)
                for (int l = 0; l < LINES; l++)
                    mem[w][l] <= '0;
        end else if (wr_en && wr_ok) begin
            mem[wr_idx][wr_line] <= wr_ent;
        end
    end

    // Indexed read-back port.
    always_comb rd_ent = rd_ok ? mem[rd_idx][rd_line] : '0;

    // Present every way of the lookup line.
    for (genvar w = 0; w < WAYS; w++) begin : g_set
        assign lk_set[w] = mem[w][lk_line];
    end

    AST_COMMIT_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_ok) |=> (mem[$past(wr_idx)][$past(wr_line)] == $past(wr_ent))); // R5
    AST_BAD_WAY_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_ok) |-> (rd_ent == '0)); // R9
endmodule

// File: rtl/assoc_tlb_regs.sv
// Maintenance registers: address (VPN), miscellaneous (PID/way/WE/RD) and
// access (frame/flags). Drives the read-back and commit requests to storage.
// Assumes one register write per cycle; select 3 is ignored.
module assoc_tlb_regs
    import assoc_tlb_pkg::*;
#(
    parameter int PID_W  = 8,
    parameter int LINE_W = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_wr,
    input  logic [1:0]          reg_sel,
    input  logic [31:0]         reg_wdata,
    input  tlb_ent_t            rd_ent,
    output logic [LINE_W-1:0]   rd_line,
    output logic [WAYF_W-1:0]   rd_way,
    output logic                cm_en,
    output logic [LINE_W-1:0]   cm_line,
    output logic [WAYF_W-1:0]   cm_way,
    output tlb_ent_t            cm_ent,
    output logic [31:0]         addr_q,
    output logic [31:0]         misc_q,
    output logic [31:0]         acc_q
);
    logic [VPN_W-1:0]   vpn_q;
    logic [PID_W-1:0]   pid_q;
    logic [WAYF_W-1:0]  way_q;
    logic               we_q;
    logic [FRAME_W-1:0] frame_q;
    logic [FLAG_W-1:0]  flags_q;

    logic misc_rd;

    // Read-back request uses the current line and the way being written.
    always_comb begin
        misc_rd = reg_wr && (reg_sel == SEL_MISC) && reg_wdata[MISC_RD_BIT];
        rd_line = vpn_q[LINE_W-1:0];
        rd_way  = reg_wdata[MISC_WAY_LSB +: WAYF_W];
    end

    // Register updates, including the read-back load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vpn_q   <= '0;
            pid_q   <= '0;
            way_q   <= '0;
            we_q    <= 1'b0;
            frame_q <= '0;
            flags_q <= '0;
        end else if (reg_wr) begin
            case (reg_sel)
                SEL_ADDR: vpn_q <= reg_wdata[ADDR_VPN_LSB +: VPN_W];
                SEL_MISC: begin
                    way_q <= reg_wdata[MISC_WAY_LSB +: WAYF_W];
                    we_q  <= reg_wdata[MISC_WE_BIT];
                    if (reg_wdata[MISC_RD_BIT]) begin
                        vpn_q   <= rd_ent.vpn;
                        pid_q   <= rd_ent.pid[PID_W-1:0];
                        frame_q <= rd_ent.frame;
                        flags_q <= rd_ent.flags;
                    end else begin
                        pid_q <= reg_wdata[MISC_PID_LSB +: PID_W];
                    end
                end
                SEL_ACC: begin
                    frame_q <= reg_wdata[ACC_FRAME_LSB +: FRAME_W];
                    flags_q <= reg_wdata[FLAG_W-1:0];
                end
                default: ;
            endcase
        end
    end

    // Commit request: access write while write-enable is held.
    always_comb begin
        cm_en           = reg_wr && (reg_sel == SEL_ACC) && we_q;
        cm_line         = vpn_q[LINE_W-1:0];
        cm_way          = way_q;
        cm_ent          = '0;
        cm_ent.vpn      = vpn_q;
        cm_ent.pid[PID_W-1:0] = pid_q;
        cm_ent.frame    = reg_wdata[ACC_FRAME_LSB +: FRAME_W];
        cm_ent.flags    = reg_wdata[FLAG_W-1:0];
    end

    // Assemble the software-visible register images.
    always_comb begin
        addr_q = '0;
        addr_q[ADDR_VPN_LSB +: VPN_W] = vpn_q;
        misc_q = '0;
        misc_q[MISC_WE_BIT] = we_q;
        misc_q[MISC_WAY_LSB +: WAYF_W] = way_q;
        misc_q[MISC_PID_LSB +: PID_W] = pid_q;
        acc_q = '0;
        acc_q[FLAG_W-1:0] = flags_q;
        acc_q[ACC_FRAME_LSB +: FRAME_W] = frame_q;
    end

    AST_READBACK_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        misc_rd |=> ((vpn_q == $past(rd_ent.vpn)) && (frame_q == $past(rd_ent.frame))
                     && (flags_q == $past(rd_ent.flags)))); // R4
    AST_ACC_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_sel == SEL_ACC) |=> (acc_q[24:0] == $past(reg_wdata[24:0]))); // R6
endmodule

// File: rtl/assoc_tlb_match.sv
// Lookup match: compares every way of the indexed line with the request
// and returns the lowest-numbered hit. Purely combinational; outputs are
// zero on a miss. Assumes PID_W <= 14.
module assoc_tlb_match
    import assoc_tlb_pkg::*;
#(
    parameter int WAYS  = 4,
    parameter int PID_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  tlb_ent_t [WAYS-1:0]  lk_set,
    input  logic [VPN_W-1:0]     req_vpn,
    input  logic [PID_W-1:0]     req_pid,
    output logic                 hit,
    output logic [FRAME_W-1:0]   frame,
    output logic [FLAG_W-1:0]    flags
);
    logic [WAYS-1:0] way_hit;

    // Per-way match: VPN equal, some permission, and global or same PID.
    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign way_hit[w] = (lk_set[w].vpn == req_vpn)
            && (lk_set[w].flags[FLG_RD] || lk_set[w].flags[FLG_WR] || lk_set[w].flags[FLG_EX])
            && (lk_set[w].flags[FLG_GL] || (lk_set[w].pid == PID_MAX_W'(req_pid)));
    end

    // Pick the lowest-numbered matching way.
    always_comb begin
        hit   = 1'b0;
        frame = '0;
        flags = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (way_hit[w]) begin
                hit   = 1'b1;
                frame = lk_set[w].frame;
                flags = lk_set[w].flags;
            end
        end
    end

    AST_HIT_HAS_PERMISSION: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (flags[FLG_RD] || flags[FLG_WR] || flags[FLG_EX])); // R7
    AST_MISS_IS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!hit) |-> ((frame == '0) && (flags == '0))); // R8
endmodule

// File: rtl/assoc_tlb.sv
// Top of the set-associative translation buffer. Connects the maintenance
// registers, entry storage and lookup match. Assumes LINES a power of two
// of at least 2, WAYS a power of two up to 16, PID_W between 8 and 14.
module assoc_tlb
    import assoc_tlb_pkg::*;
#(
    parameter int WAYS  = 4,
    parameter int LINES = 16,
    parameter int PID_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [1:0]        reg_sel,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       addr_q,
    output logic [31:0]       misc_q,
    output logic [31:0]       acc_q,
    input  logic [31:0]       lk_vaddr,
    input  logic [PID_W-1:0]  lk_pid,
    output logic              lk_hit,
    output logic [19:0]       lk_frame,
    output logic [4:0]        lk_flags
);
    localparam int LINE_W = $clog2(LINES);

    tlb_ent_t            rd_ent, cm_ent;
    tlb_ent_t [WAYS-1:0] lk_set;
    logic [LINE_W-1:0]   rd_line, cm_line, lk_line;
    logic [WAYF_W-1:0]   rd_way, cm_way;
    logic                cm_en;

    // Line index of the lookup address.
    always_comb lk_line = lk_vaddr[PAGE_SHIFT +: LINE_W];

    assoc_tlb_regs #(.PID_W(PID_W), .LINE_W(LINE_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .rd_ent(rd_ent), .rd_line(rd_line),
        .rd_way(rd_way), .cm_en(cm_en), .cm_line(cm_line), .cm_way(cm_way),
        .cm_ent(cm_ent), .addr_q(addr_q), .misc_q(misc_q), .acc_q(acc_q)
    );

    assoc_tlb_store #(.WAYS(WAYS), .LINES(LINES), .LINE_W(LINE_W)) u_store (
        .clk(clk), .rst_n(rst_n), .wr_en(cm_en), .wr_line(cm_line),
        .wr_way(cm_way), .wr_ent(cm_ent), .rd_line(rd_line), .rd_way(rd_way),
        .rd_ent(rd_ent), .lk_line(lk_line), .lk_set(lk_set)
    );

    assoc_tlb_match #(.WAYS(WAYS), .PID_W(PID_W)) u_match (
        .clk(clk), .rst_n(rst_n), .lk_set(lk_set),
        .req_vpn(lk_vaddr[31:PAGE_SHIFT]), .req_pid(lk_pid),
        .hit(lk_hit), .frame(lk_frame), .flags(lk_flags)
    );

    AST_RD_STROBE_NEVER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (misc_q[0] == 1'b0) && (misc_q[3:2] == 2'b00)); // R3
endmodule

// File: tb/assoc_tlb_test.sv
// Near-exhaustive bench over a 4-way, 8-line, 8-bit-PID configuration.
module assoc_tlb_test;
    localparam int WAYS = 4, LINES = 8, PID_W = 8, LW = 3;

    logic clk = 1'b0, rst_n = 1'b0;
    logic reg_wr = 1'b0;
    logic [1:0] reg_sel = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] addr_q, misc_q, acc_q;
    logic [31:0] lk_vaddr = '0;
    logic [PID_W-1:0] lk_pid = '0;
    logic lk_hit;
    logic [19:0] lk_frame;
    logic [4:0] lk_flags;

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    assoc_tlb #(.WAYS(WAYS), .LINES(LINES), .PID_W(PID_W)) uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .addr_q(addr_q), .misc_q(misc_q), .acc_q(acc_q),
        .lk_vaddr(lk_vaddr), .lk_pid(lk_pid), .lk_hit(lk_hit),
        .lk_frame(lk_frame), .lk_flags(lk_flags)
    );

    function automatic logic [31:0] e_vpn(int l, int w);
        return 32'(((w * 37 + 3) << LW) | l);
    endfunction
    function automatic logic [31:0] e_pid(int l, int w);
        return 32'(((l + w) % 3) + 1);
    endfunction
    function automatic logic [31:0] e_frame(int l, int w);
        return 32'('h800 + w * 'h100 + l);
    endfunction
    function automatic logic [31:0] e_flags(int l, int w);
        return 32'((((l + w) % 7) + 1) | ((((l * w) % 3) == 0) ? 8 : 0) | ((l % 2) != 0 ? 16 : 0));
    endfunction
    function automatic logic [31:0] e_acc(int l, int w);
        return (e_frame(l, w) << 5) | e_flags(l, w);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] s, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = s; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic look(input logic [31:0] va, input logic [31:0] pid);
        lk_vaddr = va; lk_pid = pid[PID_W-1:0];
        #1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 addr", addr_q, 0);
        chk("R1 misc", misc_q, 0);
        chk("R1 acc", acc_q, 0);
        look(32'h0000_0000, 0);
        chk("R1 miss", {31'd0, lk_hit}, 0);

        // R2 / R3 field layout
        wr(2'd0, 32'hFFFF_FFFF);
        chk("R2 addr field", addr_q, 32'h003F_FFFC);
        wr(2'd1, 32'hFFFF_FFFE);
        chk("R3 misc field", misc_q, 32'h0000_FFF2);
        wr(2'd3, 32'h1234_5678);
        chk("R2 select 3 ignored", addr_q, 32'h003F_FFFC);
        wr(2'd1, 0);
        wr(2'd0, 0);

        // R10 fill every (line, way)
        for (int l = 0; l < LINES; l++)
            for (int w = 0; w < WAYS; w++) begin
                wr(2'd0, e_vpn(l, w) << 2);
                wr(2'd1, 32'h2 | (32'(w) << 4) | (e_pid(l, w) << 8));
                wr(2'd2, e_acc(l, w));
            end
        // R4 R6 R10 read back every entry
        for (int l = 0; l < LINES; l++)
            for (int w = 0; w < WAYS; w++) begin
                wr(2'd0, 32'(l) << 2);
                wr(2'd1, 32'h1 | (32'(w) << 4));
                chk("R4 R10 vpn", addr_q, e_vpn(l, w) << 2);
                chk("R4 pid/way", misc_q, (32'(w) << 4) | (e_pid(l, w) << 8));
                chk("R6 access", acc_q, e_acc(l, w));
            end
        // R7 lookups with own and foreign PID
        for (int l = 0; l < LINES; l++)
            for (int w = 0; w < WAYS; w++) begin
                look((e_vpn(l, w) << 12) | 32'hABC, e_pid(l, w));
                chk("R7 hit own pid", {31'd0, lk_hit}, 1);
                chk("R7 frame", {12'd0, lk_frame}, e_frame(l, w));
                chk("R7 flags", {27'd0, lk_flags}, e_flags(l, w));
                look(e_vpn(l, w) << 12, e_pid(l, w) + 100);
                chk("R7 foreign pid global only", {31'd0, lk_hit}, (e_flags(l, w) >> 3) & 1);
            end

        // R8 priority at line 5
        wr(2'd0, ((32'd500 << LW) | 5) << 2);
        wr(2'd1, 32'h2 | (32'd1 << 4) | (32'd7 << 8));
        wr(2'd2, (32'hAAA << 5) | 1);
        wr(2'd1, 32'h2 | (32'd3 << 4) | (32'd7 << 8));
        wr(2'd2, (32'hBBB << 5) | 2);
        look(((32'd500 << LW) | 5) << 12, 7);
        chk("R8 lowest way frame", {12'd0, lk_frame}, 32'hAAA);
        chk("R8 lowest way flags", {27'd0, lk_flags}, 1);
        wr(2'd1, 32'h2 | (32'd1 << 4) | (32'd7 << 8));
        wr(2'd2, 0);
        look(((32'd500 << LW) | 5) << 12, 7);
        chk("R8 next way frame", {12'd0, lk_frame}, 32'hBBB);
        wr(2'd1, 32'h2 | (32'd3 << 4) | (32'd7 << 8));
        wr(2'd2, 0);
        look(((32'd500 << LW) | 5) << 12, 7);
        chk("R8 miss hit", {31'd0, lk_hit}, 0);
        chk("R8 miss frame", {12'd0, lk_frame}, 0);
        chk("R8 miss flags", {27'd0, lk_flags}, 0);

        // R7 permission rule at line 6 way 0
        wr(2'd0, ((32'd600 << LW) | 6) << 2);
        wr(2'd1, 32'h2 | (32'd7 << 8));
        wr(2'd2, (32'h123 << 5) | 16);
        look(((32'd600 << LW) | 6) << 12, 7);
        chk("R7 no permission misses", {31'd0, lk_hit}, 0);
        wr(2'd2, (32'h123 << 5) | 20);
        look(((32'd600 << LW) | 6) << 12, 7);
        chk("R7 exec only hits", {31'd0, lk_hit}, 1);
        look(((32'd600 << LW) | 6) << 12, 8);
        chk("R7 pid mismatch misses", {31'd0, lk_hit}, 0);

        // R5 access write without write-enable
        wr(2'd0, e_vpn(2, 2) << 2);
        wr(2'd1, (32'd2 << 4) | (32'd9 << 8));
        wr(2'd2, 32'hFFFF_FFE1);
        chk("R5 R6 acc reg updated", acc_q, 32'h01FF_FFE1);
        wr(2'd1, 32'h1 | (32'd2 << 4));
        chk("R5 entry untouched", acc_q, e_acc(2, 2));

        // R9 out-of-range way
        wr(2'd0, e_vpn(4, 0) << 2);
        wr(2'd1, 32'h2 | (32'd5 << 4) | (32'd1 << 8));
        wr(2'd2, (32'h555 << 5) | 7);
        for (int w = 0; w < WAYS; w++) begin
            wr(2'd1, 32'h1 | (32'(w) << 4));
            chk("R9 entry unchanged", acc_q, e_acc(4, w));
        end
        wr(2'd1, 32'h1 | (32'd5 << 4));
        chk("R9 read-back addr zero", addr_q, 0);
        chk("R9 read-back misc", misc_q, 32'h50);
        chk("R9 read-back acc zero", acc_q, 0);

        // R1 reset clears entries
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk); rst_n = 1'b1;
        chk("R1 acc after reset", acc_q, 0);
        wr(2'd0, 32'd1 << 2);
        wr(2'd1, 32'h1 | (32'd1 << 4));
        chk("R1 entry cleared", acc_q, 0);
        look(e_vpn(3, 2) << 12, e_pid(3, 2));
        chk("R1 lookup misses", {31'd0, lk_hit}, 0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule